// File: doc/BRIEF.md
# Dual-Divider Coincidence Sync Generator

The block takes one fast reference clock and derives two square-wave clocks from it, `q_a` and `q_c`. Each has its own even divide ratio, chosen with a 4-bit select. The two ratios need not be related. Their rising edges line up again once every common period, which is the least common multiple (LCM) of the two ratios, counted in reference cycles. The active-low strobe `sync_n` warns of that shared edge ahead of time. It goes low for one period of the faster of the two outputs and returns high exactly one such period before the edge. Downstream logic can use it to align transfers between the two domains even when neither clock is a whole multiple of the other.

All three outputs are registers clocked by the reference clock. A common-period counter sets the time base. The two dividers and the strobe shaper all follow that counter. New ratio selects are taken only at a coincidence point, so a ratio change never cuts a pulse short.

Top module: `coinc_sync_gen`

## Requirements
- R1: Select code 0,1,2,3,4,5,6,7,8 picks divide ratio 2,4,6,8,10,12,16,20,24. Codes 9 to 15 pick 24.
- R2: With ratio D, each of `q_a` and `q_c` repeats every D reference cycles. It is high for the first D/2 cycles of its period and low for the rest.
- R3: `q_a` and `q_c` both go high after the first reference edge that follows reset release. From then on they rise together every LCM(Da, Dc) reference cycles.
- R4: Take position k (0 to L−1) in the common period of length L, and let m = min(Da, Dc). With unequal ratios, `sync_n` is low exactly for L−2m ≤ k < L−m. So it is low for m cycles and rises m cycles before the shared rising edge.
- R5: When one ratio is an integer multiple of the other, the low window of R4 still holds. With L = 2m the window starts at k = 0.
- R6: When both ratios are equal, every rising edge is a coincidence, and `sync_n` stays low for as long as those ratios are active.
- R7: A change on either select is taken only at the reference edge that starts a new common period (k returns to 0). Until then the outputs keep the old ratios' pattern.
- R8: While `rst_n` is low at a reference edge, the next state has `q_a` and `q_c` low and `sync_n` high. Release restarts the common period at k = 0 with the selects present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_a | input | SEL_W (4) | Ratio select for `q_a` |
| sel_c | input | SEL_W (4) | Ratio select for `q_c` |
| q_a | output | 1 | Divided clock A |
| q_c | output | 1 | Divided clock C |
| sync_n | output | 1 | Active-low coincidence warning strobe |

## Verification
The bench drives coprime-like pairs such as 16:20 and 10:24, where the common period reaches 120 cycles. A design with a wrong LCM would move the warning pulse off the shared edge. It also drives 2:1 and 3:1 multiples, where the window starts at k = 0 and an off-by-one start shows up at once, and equal ratios, where a naive window would wrap around and pulse instead of staying low. Selects change in the middle of a period. A design that applied them at once would show a runt on a divided clock or a strobe at the wrong place before the next coincidence. Reset is asserted mid-run to check that the phase restarts cleanly. Out-of-range select codes are also driven to catch a missing saturation to 24.

// File: rtl/coinc_pkg.sv
// Shared helpers for the coincidence sync generator.
// Assumes select codes are unsigned and ratios stay small (at most 24).
package coinc_pkg;

    // Maps a select code to its even divide ratio; codes above 8 saturate.
    function automatic int unsigned ratio_of(input int unsigned code);
        case (code)
            0:       return 2;
            1:       return 4;
            2:       return 6;
            3:       return 8;
            4:       return 10;
            5:       return 12;
            6:       return 16;
            7:       return 20;
            default: return 24;
        endcase
    endfunction

    // Smallest multiple of a that b divides; bounded loop for ratios up to 24.
    function automatic int unsigned lcm_of(input int unsigned a, input int unsigned b);
        int unsigned acc;
        acc = a;
        for (int k = 0; k < 16; k++) begin
            if ((acc % b) != 0) acc = acc + a;
        end
        return acc;
    endfunction

endpackage

// File: rtl/cs_ratio_latch.sv
// Holds the active pair of divide ratios, their common period and the smaller
// ratio. New selects are taken only when load is high (a coincidence edge).
// Also exposes the values that will be active after the coming edge.
module cs_ratio_latch #(
    parameter int SEL_W = 4,
    parameter int DIV_W = 5,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEL_W-1:0] sel_a,
    input  logic [SEL_W-1:0] sel_c,
    output logic [DIV_W-1:0] div_a_q,
    output logic [DIV_W-1:0] div_c_q,
    output logic [CNT_W-1:0] per_q,
    output logic [DIV_W-1:0] min_q,
    output logic [DIV_W-1:0] div_a_nxt,
    output logic [DIV_W-1:0] div_c_nxt,
    output logic [CNT_W-1:0] per_nxt,
    output logic [DIV_W-1:0] min_nxt
);
    import coinc_pkg::*;

    int unsigned ra, rc, rl;

    // Decode selects and choose between held and freshly decoded values.
    always_comb begin
        ra = ratio_of(int'(sel_a));
        rc = ratio_of(int'(sel_c));
        rl = lcm_of(ra, rc);
        if (load) begin
            div_a_nxt = DIV_W'(ra);
            div_c_nxt = DIV_W'(rc);
            per_nxt   = CNT_W'(rl);
            min_nxt   = (ra < rc) ? DIV_W'(ra) : DIV_W'(rc);
        end else begin
            div_a_nxt = div_a_q;
            div_c_nxt = div_c_q;
            per_nxt   = per_q;
            min_nxt   = min_q;
        end
    end

    // Register the active ratio set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_a_q <= DIV_W'(2);
            div_c_q <= DIV_W'(2);
            per_q   <= CNT_W'(2);
            min_q   <= DIV_W'(2);
        end else begin
            div_a_q <= div_a_nxt;
            div_c_q <= div_c_nxt;
            per_q   <= per_nxt;
            min_q   <= min_nxt;
        end
    end

endmodule

// File: rtl/cs_period_counter.sv
// Counts reference cycles through one common period (0 .. per-1).
// wrap marks the edge that starts a new period; the first edge after reset
// always wraps so both dividers start together at position zero.
module cs_period_counter #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] per,
    output logic             wrap,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt
);
    logic run_q;

    // Decide whether the coming edge starts a new common period.
    always_comb begin
        wrap    = !run_q || (cnt_q == per - CNT_W'(1));
        cnt_nxt = wrap ? '0 : cnt_q + CNT_W'(1);
    end

    // Advance the position counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else begin
            cnt_q <= cnt_nxt;
            run_q <= 1'b1;
        end
    end

endmodule

// File: rtl/cs_divider.sv
// Even-ratio divider producing a registered 50% square wave.
// Assumes div is even and at least 2; restart forces phase zero (output high).
module cs_divider #(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             q
);
    logic [DIV_W-1:0] ph_q, ph_nxt;

    // Next phase within the divided period.
    always_comb begin
        if (restart || ph_q == div - DIV_W'(1)) ph_nxt = '0;
        else                                     ph_nxt = ph_q + DIV_W'(1);
    end

    // Register phase and the square-wave level for that phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= '0;
            q    <= 1'b0;
        end else begin
            ph_q <= ph_nxt;
            q    <= (ph_nxt < (div >> 1));
        end
    end

endmodule

// File: rtl/cs_sync_shaper.sv
// Registers the active-low warning strobe from the next period position.
// Low window is [per-2*mn, per-mn); equal ratios (per == mn) hold it low.
module cs_sync_shaper #(
    parameter int DIV_W = 5,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] pos,
    input  logic [CNT_W-1:0] per,
    input  logic [DIV_W-1:0] mn,
    output logic             sync_n
);
    localparam int EW = (CNT_W > DIV_W ? CNT_W : DIV_W) + 2;

    logic [EW-1:0] pos_e, per_e, mn_e;
    logic          low;

    // Window decode in a widened domain so the sums cannot overflow.
    always_comb begin
        pos_e = EW'(pos);
        per_e = EW'(per);
        mn_e  = EW'(mn);
        low   = (per_e == mn_e) ||
                ((pos_e + (mn_e << 1) >= per_e) && (pos_e + mn_e < per_e));
    end

    // Register the strobe; high during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_n <= 1'b1;
        else        sync_n <= !low;
    end

endmodule

// File: rtl/coinc_sync_gen.sv
// Top level: two programmable even dividers sharing one common-period counter
// and an active-low strobe that precedes their coincident rising edge.
// Assumes one reference clock and a synchronous active-low reset.
module coinc_sync_gen #(
    parameter int SEL_W = 4,
    parameter int DIV_W = 5,
    parameter int CNT_W = 7
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_a,
    input  logic [SEL_W-1:0] sel_c,
    output logic             q_a,
    output logic             q_c,
    output logic             sync_n
);
    localparam int NDIV = 2;

    logic             wrap;
    logic [CNT_W-1:0] cnt_q, cnt_nxt, per_q, per_nxt;
    logic [DIV_W-1:0] div_a_q, div_c_q, min_q, min_nxt;
    logic [DIV_W-1:0] div_a_nxt, div_c_nxt;
    logic [DIV_W-1:0] div_sel [NDIV];
    logic [NDIV-1:0]  q_vec;

    cs_ratio_latch #(.SEL_W(SEL_W), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_latch (
        .clk(clk_ref), .rst_n(rst_n), .load(wrap),
        .sel_a(sel_a), .sel_c(sel_c),
        .div_a_q(div_a_q), .div_c_q(div_c_q), .per_q(per_q), .min_q(min_q),
        .div_a_nxt(div_a_nxt), .div_c_nxt(div_c_nxt),
        .per_nxt(per_nxt), .min_nxt(min_nxt)
    );

    cs_period_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk_ref), .rst_n(rst_n), .per(per_q),
        .wrap(wrap), .cnt_q(cnt_q), .cnt_nxt(cnt_nxt)
    );

    assign div_sel[0] = div_a_nxt;
    assign div_sel[1] = div_c_nxt;

    for (genvar g = 0; g < NDIV; g++) begin : g_div
        cs_divider #(.DIV_W(DIV_W)) u_div (
            .clk(clk_ref), .rst_n(rst_n), .restart(wrap),
            .div(div_sel[g]), .q(q_vec[g])
        );
    end

    assign q_a = q_vec[0];
    assign q_c = q_vec[1];

    cs_sync_shaper #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_sync (
        .clk(clk_ref), .rst_n(rst_n), .pos(cnt_nxt),
        .per(per_nxt), .mn(min_nxt), .sync_n(sync_n)
    );

endmodule

// File: rtl/cs_checker.sv
// Timing properties of the coincidence sync generator, bound to its top.
module cs_checker #(
    parameter int DIV_W = 5,
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wrap,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] per,
    input logic [DIV_W-1:0] mn,
    input logic [DIV_W-1:0] div_a,
    input logic [DIV_W-1:0] div_c,
    input logic             q_a,
    input logic             q_c,
    input logic             sync_n
);
    logic run_seen;
    logic rst_was_low;

    // Track whether the counter has started after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) run_seen <= 1'b0;
        else        run_seen <= 1'b1;
    end

    AST_JOINT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_seen && cnt == '0) |-> (q_a && q_c)); // R3

    AST_SYNC_FALL_POS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_n) |-> (cnt == '0 || int'(cnt) + 2 * int'(mn) == int'(per))); // R4

    AST_SYNC_RISE_POS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_n) |-> (cnt == '0 || int'(cnt) + int'(mn) == int'(per))); // R4

    AST_RATIO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> ($stable(div_a) && $stable(div_c))); // R7

    // Outputs settle to their reset levels one edge after reset is seen.
    always_ff @(posedge clk) begin
        rst_was_low <= !rst_n;
        if (rst_was_low) begin
            AST_RESET_QUIET: assert (!q_a && !q_c && sync_n); // R8
        end
    end

endmodule

bind coinc_sync_gen cs_checker #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk_ref), .rst_n(rst_n), .wrap(wrap), .cnt(cnt_q), .per(per_q),
    .mn(min_q), .div_a(div_a_q), .div_c(div_c_q),
    .q_a(q_a), .q_c(q_c), .sync_n(sync_n)
);

// File: tb/test_coinc_sync_gen.sv
`timescale 1ns/1ps
module test_coinc_sync_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] sel_a = '0;
    logic [3:0] sel_c = '0;
    logic       q_a, q_c, sync_n;

    int compared = 0;
    int mismatched = 0;

    // Behavioural model state.
    bit model_ok = 0;
    bit started = 0;
    int k = 0, da = 2, dc = 2, ll = 2;
    bit exp_qa = 0, exp_qc = 0, exp_sync = 1, in_rst = 1;

    always #4 clk = ~clk;

    coinc_sync_gen i_coinc_sync_gen (
        .clk_ref(clk), .rst_n(rst_n), .sel_a(sel_a), .sel_c(sel_c),
        .q_a(q_a), .q_c(q_c), .sync_n(sync_n)
    );

    function automatic int ratio(input int code); // R1 encoding
        int tab[9] = '{2, 4, 6, 8, 10, 12, 16, 20, 24};
        if (code > 8) return 24;
        return tab[code];
    endfunction

    function automatic int lcm(input int a, input int b);
        int x = a, y = b, t;
        while (y != 0) begin t = x % y; x = y; y = t; end
        return (a / x) * b;
    endfunction

    // Reference model stepped on each rising edge.
    always @(posedge clk) begin
        int m;
        model_ok = 1;
        if (!rst_n) begin
            started = 0; in_rst = 1;
            exp_qa = 0; exp_qc = 0; exp_sync = 1;
        end else begin
            in_rst = 0;
            if (!started || k == ll - 1) begin
                started = 1; k = 0;
                da = ratio(int'(sel_a)); dc = ratio(int'(sel_c));
                ll = lcm(da, dc);
            end else begin
                k = k + 1;
            end
            m = (da < dc) ? da : dc;
            exp_qa = (k % da) < da / 2;
            exp_qc = (k % dc) < dc / 2;
            if (ll == m) exp_sync = 0;
            else exp_sync = !((k >= ll - 2 * m) && (k < ll - m));
        end
    end

    task automatic check(input string tag, input string what, input bit act, input bit exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s at %0t: actual=%0b expected=%0b (k=%0d Da=%0d Dc=%0d)",
                     tag, what, $time, act, exp, k, da, dc);
        end
    endtask

    // Compare away from the active edge.
    always @(negedge clk) begin
        if (model_ok) begin
            if (in_rst) begin
                check("R8", "q_a", q_a, exp_qa);
                check("R8", "q_c", q_c, exp_qc);
                check("R8", "sync_n", sync_n, exp_sync);
            end else begin
                check("R1 R2 R3 R7", "q_a", q_a, exp_qa);
                check("R1 R2 R3 R7", "q_c", q_c, exp_qc);
                check("R4 R5 R6 R7", "sync_n", sync_n, exp_sync);
            end
        end
    end

    task automatic run_pair(input int a, input int c, input int cycles);
        @(negedge clk);
        sel_a = 4'(a); sel_c = 4'(c);
        repeat (cycles) @(negedge clk);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        run_pair(0, 0, 40);    // R6 equal 2:2
        run_pair(1, 2, 97);    // 4:6, change lands mid-period (R7)
        run_pair(6, 7, 263);   // 16:20, L=80
        run_pair(3, 8, 151);   // R5 8:24 multiple
        run_pair(4, 8, 377);   // 10:24, L=120
        run_pair(0, 1, 53);    // R5 2:4, window at k=0
        run_pair(8, 12, 89);   // R1 saturating code, equal 24:24 (R6)
        run_pair(2, 5, 131);   // 6:12
        @(negedge clk); rst_n = 1'b0;   // R8 mid-run reset
        sel_a = 4'd7; sel_c = 4'd6;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (250) @(negedge clk);
        run_pair(15, 3, 120);  // R1 code 15 -> 24 against 8
        run_pair(5, 4, 200);   // 12:10, L=60
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        summary();
        $finish;
    end

endmodule